// File: doc/BRIEF.md
# IR pulse-width capture receiver

This receiver times the mark and space intervals of an infrared level that has already been demodulated from its carrier, or that never had one. A glitch filter rejects short pulses first. A selectable edge detector then starts and stops a pulse-width timer. That timer advances once per period of a programmable receive-clock divider. Each finished interval becomes a record that holds the upper timer bits and the level of the interval. The record is queued in a small receive FIFO that software drains one word at a time.

The block raises three sticky conditions: a FIFO service request, a FIFO overrun and a timer timeout. Each condition has its own interrupt enable. The overrun and timeout flags cannot be cleared by a read. They clear only when the FIFO enable or the receiver enable is dropped. A timeout writes an all-ones marker record. Software reads that marker as "no IR activity".

Top module: `irpw_rx`

## Requirements
- R1: `edge_sel_i` picks which filtered edges close an interval: 0 selects no edge, 1 falling edges, 2 rising edges and 3 both. The first selected edge after the receiver is enabled only starts timing and writes no record.
- R2: The timer advances once every `div_i`+1 clock cycles. An interval of L cycles between two selected edges leaves floor((L-1)/(`div_i`+1)) in the timer when the record is formed.
- R3: The record format is fixed. Bits [TMR_W-3:0] hold timer bits [TMR_W-1:2]. Bit TMR_W-2 holds the filtered level just before the closing edge. In the read word `rd_data_o`, bit TMR_W-1 is a new-data-valid flag, and a read of an empty FIFO returns all zeros.
- R4: When the timer would wrap, the all-ones record is written and the timeout flag is set. No further record is written until the next selected edge.
- R5: The timeout flag stays set until `rx_en_i` is low at a clock edge.
- R6: The FIFO holds DEPTH (default 8) records and returns them in arrival order.
- R7: A record that arrives while the FIFO is full is discarded and sets the overrun flag. The overrun flag clears only when `fifo_en_i` is low, and that same condition empties the FIFO.
- R8: `svc_mode_i`=1 makes the service request follow "FIFO not empty". `svc_mode_i`=0 makes it follow "FIFO at least half full".
- R9: A change of `ir_i` reaches the filtered level only after it has been stable for `flt_min_i` clock cycles. A shorter pulse is rejected. A count of 0 disables the filter.
- R10: Each interrupt output equals its status flag ANDed with its enable.
- R11: Dropping `rx_en_i` stops timing but keeps the records already queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ir_i | input | 1 | Demodulated IR level |
| rx_en_i | input | 1 | Receiver enable; low clears timeout flag |
| fifo_en_i | input | 1 | FIFO enable; low empties FIFO and clears overrun |
| edge_sel_i | input | 2 | Interval-closing edge select |
| svc_mode_i | input | 1 | Service watermark: 1 not empty, 0 half full |
| div_i | input | DIV_W (16) | Receive-clock divider reload |
| flt_min_i | input | FLT_W (16) | Minimum accepted pulse length in clocks |
| to_ie_i | input | 1 | Timeout interrupt enable |
| ovr_ie_i | input | 1 | Overrun interrupt enable |
| svc_ie_i | input | 1 | Service-request interrupt enable |
| rd_i | input | 1 | Pop the head record |
| rd_data_o | output | TMR_W (18) | {valid, level, timer[TMR_W-1:2]} of the head record |
| svc_o | output | 1 | Service request status |
| ovr_o | output | 1 | Overrun status |
| to_o | output | 1 | Timeout status |
| irq_to_o | output | 1 | Timeout interrupt |
| irq_ovr_o | output | 1 | Overrun interrupt |
| irq_svc_o | output | 1 | Service-request interrupt |

## Verification
Several input patterns are driven, and each separates a different fault:
- Alternating marks and spaces of unequal length with both edges selected confirm the width arithmetic and the level bit.
- A rising-only sequence shows that single-edge mode measures whole periods.
- Toggles with no edge selected must leave the FIFO empty.
- A long mark run through a divider of 3 checks the tick rate.
- A mark split by a 4-cycle gap, against a 5-cycle filter minimum, checks rejection at the boundary.
- A train of ten short intervals fills the FIFO past its half-full point and into overrun.
- An idle tail lets the timer wrap into the timeout marker.

// File: rtl/irpw_pkg.sv
package irpw_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  function automatic logic edge_hit(edge_sel_e sel, logic rise, logic fall);
    return ((sel == EDGE_RISE || sel == EDGE_BOTH) && rise) ||
           ((sel == EDGE_FALL || sel == EDGE_BOTH) && fall);
  endfunction
endpackage

// File: rtl/irpw_glitch_filter.sv
module irpw_glitch_filter #(
  parameter int FLT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic [FLT_W-1:0] min_i,
  output logic             lvl_o
);
  logic [FLT_W-1:0] cnt_q;
  logic [FLT_W:0]   nxt;
  logic             lvl_q;

  assign nxt   = {1'b0, cnt_q} + (FLT_W+1)'(1);
  assign lvl_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (raw_i == lvl_q) begin
      cnt_q <= '0;
    end else if (nxt >= {1'b0, min_i}) begin
      lvl_q <= raw_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= nxt[FLT_W-1:0];
    end
  end

  assert_filter_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i == lvl_o) |=> $stable(lvl_o));
endmodule

// File: rtl/irpw_width_timer.sv
module irpw_width_timer
  import irpw_pkg::*;
#(
  parameter int TMR_W = 18,
  parameter int DIV_W = 16,
  localparam int REC_W = TMR_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             lvl_i,
  input  logic [1:0]       edge_sel_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             push_o,
  output logic [REC_W-1:0] rec_o,
  output logic             tout_o
);
  logic [TMR_W-1:0] tmr_q;
  logic [DIV_W-1:0] div_q;
  logic             armed_q, lvl_q, push_q, tout_q, hit;
  logic [REC_W-1:0] rec_q;

  assign hit    = edge_hit(edge_sel_e'(edge_sel_i), lvl_i & ~lvl_q, ~lvl_i & lvl_q);
  assign push_o = push_q;
  assign rec_o  = rec_q;
  assign tout_o = tout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q   <= '0;
      div_q   <= '0;
      armed_q <= 1'b0;
      lvl_q   <= 1'b0;
      push_q  <= 1'b0;
      tout_q  <= 1'b0;
      rec_q   <= '0;
    end else begin
      lvl_q  <= lvl_i;
      push_q <= 1'b0;
      tout_q <= 1'b0;
      if (!en_i) begin
        armed_q <= 1'b0;
        tmr_q   <= '0;
        div_q   <= div_i;
      end else if (hit) begin
        if (armed_q) begin
          push_q <= 1'b1;
          rec_q  <= {lvl_q, tmr_q[TMR_W-1:2]};
        end
        armed_q <= 1'b1;
        tmr_q   <= '0;
        div_q   <= div_i;
      end else if (armed_q) begin
        if (div_q == '0) begin
          div_q <= div_i;
          if (&tmr_q) begin
            push_q  <= 1'b1;
            rec_q   <= '1;
            tout_q  <= 1'b1;
            armed_q <= 1'b0;
            tmr_q   <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end else begin
          div_q <= div_q - 1'b1;
        end
      end
    end
  end

  assert_no_push_after_timeout_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tout_o |=> !push_o);
endmodule

// File: rtl/irpw_rx_fifo.sv
module irpw_rx_fifo #(
  parameter int DW    = 17,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o,
  output logic          drop_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic          full, pop, wr_ok;

  assign full    = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign pop     = rd_i & ~empty_o;
  assign wr_ok   = wr_i & (~full | pop);
  assign drop_o  = wr_i & full & ~pop;
  assign rdata_o = mem_q[rptr_q];
  assign count_o = count_q;

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else if (clr_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (wr_ok) wptr_q <= wptr_q + 1'b1;
      if (pop)   rptr_q <= rptr_q + 1'b1;
      case ({wr_ok, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assert_count_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
endmodule

// File: rtl/irpw_rx.sv
module irpw_rx #(
  parameter int TMR_W = 18,
  parameter int DIV_W = 16,
  parameter int FLT_W = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ir_i,
  input  logic             rx_en_i,
  input  logic             fifo_en_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             svc_mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [FLT_W-1:0] flt_min_i,
  input  logic             to_ie_i,
  input  logic             ovr_ie_i,
  input  logic             svc_ie_i,
  input  logic             rd_i,
  output logic [TMR_W-1:0] rd_data_o,
  output logic             svc_o,
  output logic             ovr_o,
  output logic             to_o,
  output logic             irq_to_o,
  output logic             irq_ovr_o,
  output logic             irq_svc_o
);
  localparam int REC_W = TMR_W - 1;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic             flt_lvl, push, tout, empty, drop;
  logic [REC_W-1:0] rec, head;
  logic [CW-1:0]    count;
  logic             ovr_q, to_q;

  irpw_glitch_filter #(.FLT_W(FLT_W)) u_flt (
    .clk_i, .rst_ni, .raw_i(ir_i), .min_i(flt_min_i), .lvl_o(flt_lvl)
  );

  irpw_width_timer #(.TMR_W(TMR_W), .DIV_W(DIV_W)) u_tmr (
    .clk_i, .rst_ni, .en_i(rx_en_i), .lvl_i(flt_lvl), .edge_sel_i,
    .div_i, .push_o(push), .rec_o(rec), .tout_o(tout)
  );

  irpw_rx_fifo #(.DW(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .clr_i(~fifo_en_i), .wr_i(push & fifo_en_i),
    .wdata_i(rec), .rd_i, .rdata_o(head), .empty_o(empty),
    .count_o(count), .drop_o(drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      if (!fifo_en_i) ovr_q <= 1'b0;
      else if (drop)  ovr_q <= 1'b1;
      if (!rx_en_i)   to_q  <= 1'b0;
      else if (tout)  to_q  <= 1'b1;
    end
  end

  assign rd_data_o = {~empty, empty ? '0 : head};
  assign svc_o     = svc_mode_i ? ~empty : (count >= CW'(DEPTH / 2));
  assign ovr_o     = ovr_q;
  assign to_o      = to_q;
  assign irq_to_o  = to_q  & to_ie_i;
  assign irq_ovr_o = ovr_q & ovr_ie_i;
  assign irq_svc_o = svc_o & svc_ie_i;

  assert_ovr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && fifo_en_i) |=> ovr_q);
  assert_drop_sets_ovr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> ovr_q);
  assert_to_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_q && rx_en_i) |=> to_q);
endmodule

// File: tb/irpw_rx_bench.sv
module irpw_rx_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ir_i = 1'b0, rx_en_i = 1'b0, fifo_en_i = 1'b0;
  logic [1:0]  edge_sel_i = 2'd0;
  logic        svc_mode_i = 1'b0;
  logic [15:0] div_i = '0, flt_min_i = '0;
  logic        to_ie_i = 1'b0, ovr_ie_i = 1'b0, svc_ie_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  rd_data_o;
  logic        svc_o, ovr_o, to_o, irq_to_o, irq_ovr_o, irq_svc_o;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  irpw_rx #(.TMR_W(8), .DEPTH(8)) u_irpw_rx (
    .clk_i(clk), .rst_ni, .ir_i, .rx_en_i, .fifo_en_i, .edge_sel_i,
    .svc_mode_i, .div_i, .flt_min_i, .to_ie_i, .ovr_ie_i, .svc_ie_i,
    .rd_i, .rd_data_o, .svc_o, .ovr_o, .to_o, .irq_to_o, .irq_ovr_o, .irq_svc_o
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    ir_i = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic read_chk(input string tag, input logic [7:0] exp);
    check(tag, 32'(rd_data_o), 32'(exp));
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R3 reset read word", 32'(rd_data_o), 32'h0);
    check("R8 reset svc", 32'(svc_o), 32'h0);
    check("R7 reset ovr", 32'(ovr_o), 32'h0);
    check("R4 reset timeout", 32'(to_o), 32'h0);
  endtask

  task automatic t_both_edges();
    fifo_en_i = 1'b1; rx_en_i = 1'b1; edge_sel_i = 2'd3; div_i = 16'd0;
    svc_mode_i = 1'b1; to_ie_i = 1'b1; ovr_ie_i = 1'b1; svc_ie_i = 1'b1;
    hold(0, 5);
    hold(1, 20); hold(0, 40); hold(1, 12); hold(0, 5);
    check("R8 svc not-empty mode", 32'(svc_o), 32'h1);
    read_chk("R1 R2 R3 mark 20", 8'hC4);
    read_chk("R3 R6 space 40", 8'h89);
    read_chk("R6 mark 12", 8'hC2);
    read_chk("R3 empty read", 8'h00);
  endtask

  task automatic t_timeout();
    hold(0, 300);
    check("R4 timeout flag", 32'(to_o), 32'h1);
    check("R10 timeout irq", 32'(irq_to_o), 32'h1);
    read_chk("R4 marker record", 8'hFF);
    read_chk("R4 single marker", 8'h00);
    to_ie_i = 1'b0; #1;
    check("R10 timeout irq masked", 32'(irq_to_o), 32'h0);
    to_ie_i = 1'b1;
    hold(0, 20);
    check("R5 timeout sticky", 32'(to_o), 32'h1);
    rx_en_i = 1'b0; @(negedge clk);
    check("R5 timeout cleared", 32'(to_o), 32'h0);
    rx_en_i = 1'b1; @(negedge clk);
  endtask

  task automatic t_single_edge();
    rx_en_i = 1'b0; edge_sel_i = 2'd2; @(negedge clk);
    rx_en_i = 1'b1;
    hold(1, 10); hold(0, 15); hold(1, 10); hold(0, 5);
    read_chk("R1 rising-only period", 8'h86);
    read_chk("R1 rising-only count", 8'h00);
    rx_en_i = 1'b0; edge_sel_i = 2'd0; @(negedge clk);
    rx_en_i = 1'b1;
    hold(1, 10); hold(0, 10); hold(1, 10); hold(0, 10);
    check("R1 no edge no record", 32'(rd_data_o), 32'h0);
    check("R1 no edge no svc", 32'(svc_o), 32'h0);
    rx_en_i = 1'b0; @(negedge clk);
  endtask

  task automatic t_divider();
    edge_sel_i = 2'd3; div_i = 16'd3; rx_en_i = 1'b1;
    hold(0, 4); hold(1, 81); hold(0, 5);
    read_chk("R2 divider 3", 8'hC5);
    rx_en_i = 1'b0; div_i = 16'd0; @(negedge clk);
  endtask

  task automatic t_filter();
    flt_min_i = 16'd5; rx_en_i = 1'b1;
    hold(0, 10);
    hold(1, 30); hold(0, 4); hold(1, 30); hold(0, 12);
    read_chk("R9 glitch rejected", 8'hCF);
    read_chk("R9 single record", 8'h00);
    rx_en_i = 1'b0; flt_min_i = 16'd0; @(negedge clk);
  endtask

  task automatic t_fill_overrun();
    svc_mode_i = 1'b0; edge_sel_i = 2'd3; rx_en_i = 1'b1;
    hold(0, 4);
    for (int j = 0; j <= 9; j++) begin
      hold((j % 2 == 0), (j == 8) ? 16 : 8);
      if (j == 3) check("R8 svc below half", 32'(svc_o), 32'h0);
      if (j == 4) begin
        check("R8 svc at half", 32'(svc_o), 32'h1);
        check("R10 svc irq", 32'(irq_svc_o), 32'h1);
      end
      if (j == 8) check("R7 full no ovr", 32'(ovr_o), 32'h0);
    end
    check("R7 overrun set", 32'(ovr_o), 32'h1);
    check("R10 overrun irq", 32'(irq_ovr_o), 32'h1);
    rx_en_i = 1'b0; hold(0, 2);
    for (int k = 1; k <= 8; k++)
      read_chk("R6 R11 fifo order kept", (k % 2 == 1) ? 8'hC1 : 8'h81);
    read_chk("R7 newest discarded", 8'h00);
    check("R7 ovr sticky after reads", 32'(ovr_o), 32'h1);
    fifo_en_i = 1'b0; @(negedge clk);
    check("R7 ovr cleared", 32'(ovr_o), 32'h0);
    fifo_en_i = 1'b1; @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_both_edges();
    t_timeout();
    t_single_edge();
    t_divider();
    t_filter();
    t_fill_overrun();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule